// File: doc/BRIEF.md
# NAND page layout de-interleaver

The block takes one raw NAND page as a byte stream and splits it according to a fixed controller layout. The layout is a short metadata prefix, then a number of data chunks, each followed by its own ECC field, then a few pad bytes at the end. The default sizes are a 10-byte prefix, four 512-byte chunks, 13-byte ECC fields and 2 pad bytes, 2112 bytes in all. The whole page is held in an internal buffer. While the page streams in, each prefix byte, chunk byte and ECC byte is also forwarded on a side port. Each forwarded byte carries a segment kind and a chunk index. The last byte of each ECC field is flagged, and that flag says whether the whole field was 0xFF (an erased chunk). An external corrector can then decode the chunks and skip the erased ones.

The first ECC field covers the prefix together with chunk 0, so prefix bytes are tagged with chunk index 0. After a good page, the block accepts nothing more and waits. In that time the corrector writes repaired bytes into the buffer through a write port, using raw page offsets. It then raises the done strobe. The block then exchanges buffer byte 0 with the byte at raw offset `SWAP_OFS` (default 2048). This restores the factory bad-block marker, which the writer had moved there before computing ECC. After the exchange, the block emits the prefix bytes on a strobed metadata output. Last, it streams the concatenated chunk bytes, with ECC and pad removed, on a valid/ready output.

A frame whose end marker arrives at any byte count other than the page length raises a one-cycle length error. Such a frame is dropped.

Top module: `nand_page_fmt`

## Requirements
- R1: After reset and during reception `in_ready_o` is high, and bytes are accepted on each cycle with `in_valid_i` high. Raw offset k of the frame is the k-th accepted byte.
- R2: For each accepted byte the side port is valid, with `side_kind_o` = 0 for prefix bytes, 1 for chunk bytes and 2 for ECC bytes. Prefix bytes carry chunk index 0, and chunk and ECC bytes carry their chunk number. Pad bytes and bytes past the page length are not forwarded.
- R3: `ecc_end_o` is high exactly with the last byte of each ECC field. `ecc_erased_o` is high at that moment only if every byte of that field was 0xFF.
- R4: If the frame's last byte arrives at a byte count other than the page length, `len_err_o` is high for one cycle on the cycle after it. The frame is discarded, with no output, and `in_ready_o` stays high. Done strobes during reception are ignored.
- R5: After a correct-length page, `in_ready_o` is low and no metadata or user output appears until `corr_done_i` is seen.
- R6: While waiting, `fix_we_i` writes `fix_data_i` to raw offset `fix_addr_i`, and the written value appears in the output.
- R7: The bytes at raw offsets 0 and `SWAP_OFS` are exchanged after correction. A fix write given in the same cycle as `corr_done_i` is included before the exchange.
- R8: Two cycles after `corr_done_i` is sampled, `meta_valid_o` is high for `META_LEN` consecutive cycles, carrying buffer bytes 0 to `META_LEN`-1 in order. User output stays low during this time.
- R9: The user stream is `N_CHUNKS*CHUNK_LEN` bytes: chunk 0 to the last chunk in order, with no ECC or pad bytes. `out_last_o` is high on the final byte.
- R10: While `out_valid_o` is high and `out_ready_i` is low, `out_data_o` and `out_last_o` hold.
- R11: The cycle after the final user byte is taken, `in_ready_o` is high again for the next page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Raw byte valid |
| in_data_i | input | 8 | Raw page byte |
| in_last_i | input | 1 | Last byte of frame |
| in_ready_o | output | 1 | Block accepts raw bytes |
| side_valid_o | output | 1 | Forwarded byte valid |
| side_data_o | output | 8 | Forwarded byte |
| side_kind_o | output | 2 | 0 prefix, 1 chunk, 2 ECC |
| side_idx_o | output | IW (2) | Chunk index |
| ecc_end_o | output | 1 | Last byte of an ECC field |
| ecc_erased_o | output | 1 | That ECC field was all 0xFF |
| len_err_o | output | 1 | Frame length error pulse |
| fix_we_i | input | 1 | Corrected byte write |
| fix_addr_i | input | AW (12) | Raw offset of corrected byte |
| fix_data_i | input | 8 | Corrected byte |
| corr_done_i | input | 1 | Correction finished |
| meta_valid_o | output | 1 | Metadata byte strobe |
| meta_data_o | output | 8 | Metadata byte |
| out_valid_o | output | 1 | User byte valid |
| out_ready_i | input | 1 | Consumer accepts user byte |
| out_data_o | output | 8 | User byte |
| out_last_o | output | 1 | Final user byte |

## Verification
A corrector write and the done strobe can fall in the same cycle. The exchange runs on the very next cycle, so that write must already be in the buffer when the exchange reads it. The bench provokes this on every page by issuing a fix write together with `corr_done_i`. The write target alternates between offset 0 and `SWAP_OFS`. The bench judges the result by where the written value reappears: as metadata byte 0 when it targeted `SWAP_OFS`, or in the user stream at the swap position when it targeted offset 0.

// File: rtl/nand_page_fmt_pkg.sv
package nand_page_fmt_pkg;
  typedef enum logic [1:0] {
    SEG_META = 2'd0,
    SEG_DATA = 2'd1,
    SEG_ECC  = 2'd2,
    SEG_PAD  = 2'd3
  } seg_e;

  typedef enum logic [2:0] {
    ST_RECV,
    ST_WAIT,
    ST_SWAP,
    ST_META,
    ST_USER
  } state_e;
endpackage

// File: rtl/nand_page_fmt_rxmap.sv
module nand_page_fmt_rxmap
  import nand_page_fmt_pkg::*;
#(
  parameter int META_LEN  = 10,
  parameter int CHUNK_LEN = 512,
  parameter int ECC_LEN   = 13,
  parameter int PAD_LEN   = 2,
  parameter int N_CHUNKS  = 4,
  parameter int IW        = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic          clear_i,
  output seg_e          kind_o,
  output logic [IW-1:0] idx_o,
  output logic          first_o,
  output logic          last_o,
  output logic          over_o
);
  localparam int L1 = (META_LEN > CHUNK_LEN) ? META_LEN : CHUNK_LEN;
  localparam int L2 = (ECC_LEN > PAD_LEN) ? ECC_LEN : PAD_LEN;
  localparam int LMAX = (L1 > L2) ? L1 : L2;
  localparam int SW = $clog2(LMAX + 1);

  logic [SW-1:0] seg_cnt, seg_len;

  always_comb begin
    case (kind_o)
      SEG_META: seg_len = SW'(META_LEN);
      SEG_DATA: seg_len = SW'(CHUNK_LEN);
      SEG_ECC:  seg_len = SW'(ECC_LEN);
      default:  seg_len = SW'(PAD_LEN);
    endcase
  end

  assign first_o = (seg_cnt == '0);
  assign last_o  = (seg_cnt == seg_len - SW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_o  <= SEG_META;
      idx_o   <= '0;
      seg_cnt <= '0;
      over_o  <= 1'b0;
    end else if (clear_i) begin
      kind_o  <= SEG_META;
      idx_o   <= '0;
      seg_cnt <= '0;
      over_o  <= 1'b0;
    end else if (step_i && !over_o) begin
      if (last_o) begin
        seg_cnt <= '0;
        case (kind_o)
          SEG_META: kind_o <= SEG_DATA;
          SEG_DATA: kind_o <= SEG_ECC;
          SEG_ECC: begin
            if (idx_o == IW'(N_CHUNKS - 1)) kind_o <= SEG_PAD;
            else begin
              kind_o <= SEG_DATA;
              idx_o  <= idx_o + IW'(1);
            end
          end
          default: over_o <= 1'b1;
        endcase
      end else begin
        seg_cnt <= seg_cnt + SW'(1);
      end
    end
  end
endmodule

// File: rtl/nand_page_fmt_txaddr.sv
module nand_page_fmt_txaddr #(
  parameter int META_LEN  = 10,
  parameter int CHUNK_LEN = 512,
  parameter int ECC_LEN   = 13,
  parameter int N_CHUNKS  = 4,
  parameter int AW        = 12,
  parameter int IW        = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          adv_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);
  localparam int OW = $clog2(CHUNK_LEN + 1);

  logic [OW-1:0] in_cnt;
  logic [IW-1:0] ch;
  logic          chunk_end;

  assign chunk_end = (in_cnt == OW'(CHUNK_LEN - 1));
  assign last_o    = chunk_end && (ch == IW'(N_CHUNKS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= AW'(META_LEN);
      in_cnt <= '0;
      ch     <= '0;
    end else if (start_i) begin
      addr_o <= AW'(META_LEN);
      in_cnt <= '0;
      ch     <= '0;
    end else if (adv_i) begin
      if (chunk_end) begin
        // hop over the ECC field that follows the chunk
        addr_o <= addr_o + AW'(ECC_LEN + 1);
        in_cnt <= '0;
        ch     <= ch + IW'(1);
      end else begin
        addr_o <= addr_o + AW'(1);
        in_cnt <= in_cnt + OW'(1);
      end
    end
  end
endmodule

// File: rtl/nand_page_fmt.sv
module nand_page_fmt
  import nand_page_fmt_pkg::*;
#(
  parameter int META_LEN  = 10,
  parameter int CHUNK_LEN = 512,
  parameter int ECC_LEN   = 13,
  parameter int PAD_LEN   = 2,
  parameter int N_CHUNKS  = 4,
  parameter int SWAP_OFS  = 2048,
  localparam int PAGE_LEN = META_LEN + N_CHUNKS * (CHUNK_LEN + ECC_LEN) + PAD_LEN,
  localparam int AW       = $clog2(PAGE_LEN),
  localparam int IW       = (N_CHUNKS > 1) ? $clog2(N_CHUNKS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic [7:0]    in_data_i,
  input  logic          in_last_i,
  output logic          in_ready_o,
  output logic          side_valid_o,
  output logic [7:0]    side_data_o,
  output logic [1:0]    side_kind_o,
  output logic [IW-1:0] side_idx_o,
  output logic          ecc_end_o,
  output logic          ecc_erased_o,
  output logic          len_err_o,
  input  logic          fix_we_i,
  input  logic [AW-1:0] fix_addr_i,
  input  logic [7:0]    fix_data_i,
  input  logic          corr_done_i,
  output logic          meta_valid_o,
  output logic [7:0]    meta_data_o,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [7:0]    out_data_o,
  output logic          out_last_o
);
  localparam int CW = $clog2(PAGE_LEN + 1);

  state_e        st;
  logic [7:0]    mem [PAGE_LEN];
  logic [CW-1:0] cnt;
  logic [AW-1:0] meta_cnt, tx_addr;
  logic          acc, good_len, tx_last, erased_acc, byte_ff;
  seg_e          kind;
  logic [IW-1:0] idx;
  logic          seg_first, seg_last, over;

  assign in_ready_o = (st == ST_RECV);
  assign acc        = in_valid_i && in_ready_o;
  assign good_len   = (cnt == CW'(PAGE_LEN - 1));
  assign byte_ff    = (in_data_i == 8'hFF);

  nand_page_fmt_rxmap #(
    .META_LEN(META_LEN), .CHUNK_LEN(CHUNK_LEN), .ECC_LEN(ECC_LEN),
    .PAD_LEN(PAD_LEN), .N_CHUNKS(N_CHUNKS), .IW(IW)
  ) u_rxmap (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .step_i(acc), .clear_i(acc && in_last_i),
    .kind_o(kind), .idx_o(idx), .first_o(seg_first), .last_o(seg_last), .over_o(over)
  );

  assign side_valid_o = acc && (kind != SEG_PAD) && !over;
  assign side_data_o  = in_data_i;
  assign side_kind_o  = kind;
  assign side_idx_o   = idx;
  assign ecc_end_o    = acc && (kind == SEG_ECC) && seg_last && !over;
  assign ecc_erased_o = ecc_end_o && byte_ff && (seg_first || erased_acc);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) erased_acc <= 1'b0;
    else if (acc && kind == SEG_ECC) erased_acc <= byte_ff && (seg_first || erased_acc);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st        <= ST_RECV;
      cnt       <= '0;
      meta_cnt  <= '0;
      len_err_o <= 1'b0;
    end else begin
      len_err_o <= acc && in_last_i && !good_len;
      case (st)
        ST_RECV: begin
          if (acc) begin
            if (in_last_i) begin
              cnt <= '0;
              if (good_len) st <= ST_WAIT;
            end else if (cnt != CW'(PAGE_LEN)) begin
              cnt <= cnt + CW'(1);
            end
          end
        end
        ST_WAIT: if (corr_done_i) st <= ST_SWAP;
        ST_SWAP: begin
          meta_cnt <= '0;
          st       <= ST_META;
        end
        ST_META: begin
          if (meta_cnt == AW'(META_LEN - 1)) st <= ST_USER;
          else meta_cnt <= meta_cnt + AW'(1);
        end
        default: if (out_ready_i && tx_last) st <= ST_RECV;
      endcase
    end
  end

  // page buffer: fill, corrector write-back, then marker exchange
  always_ff @(posedge clk_i) begin
    if (acc && (cnt < CW'(PAGE_LEN))) begin
      mem[cnt[AW-1:0]] <= in_data_i;
    end else if (st == ST_WAIT && fix_we_i && ({1'b0, fix_addr_i} < (AW + 1)'(PAGE_LEN))) begin
      mem[fix_addr_i] <= fix_data_i;
    end else if (st == ST_SWAP) begin
      mem[0]            <= mem[AW'(SWAP_OFS)];
      mem[AW'(SWAP_OFS)] <= mem[0];
    end
  end

  nand_page_fmt_txaddr #(
    .META_LEN(META_LEN), .CHUNK_LEN(CHUNK_LEN), .ECC_LEN(ECC_LEN),
    .N_CHUNKS(N_CHUNKS), .AW(AW), .IW(IW)
  ) u_txaddr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(st == ST_SWAP), .adv_i(st == ST_USER && out_ready_i),
    .addr_o(tx_addr), .last_o(tx_last)
  );

  assign meta_valid_o = (st == ST_META);
  assign meta_data_o  = mem[meta_cnt];
  assign out_valid_o  = (st == ST_USER);
  assign out_data_o   = mem[tx_addr];
  assign out_last_o   = out_valid_o && tx_last;
endmodule

// File: rtl/nand_page_fmt_chk.sv
module nand_page_fmt_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       in_valid_i,
  input logic       in_last_i,
  input logic       in_ready_o,
  input logic       ecc_end_o,
  input logic       ecc_erased_o,
  input logic       len_err_o,
  input logic       meta_valid_o,
  input logic       out_valid_o,
  input logic       out_ready_i,
  input logic [7:0] out_data_o,
  input logic       out_last_o
);
  a_r10_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_last_o));

  a_r8_one_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({in_ready_o, meta_valid_o, out_valid_o}));

  a_r4_err_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_err_o |-> $past(in_valid_i && in_ready_o && in_last_i));

  a_r3_erased_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ecc_erased_o |-> ecc_end_o);

  a_r11_ready_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && out_last_o |=> in_ready_o);

  a_r5_hold_after_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && in_last_i && !ecc_end_o && !ecc_erased_o |=> !out_valid_o);
endmodule

bind nand_page_fmt nand_page_fmt_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_last_i(in_last_i),
  .in_ready_o(in_ready_o), .ecc_end_o(ecc_end_o), .ecc_erased_o(ecc_erased_o),
  .len_err_o(len_err_o), .meta_valid_o(meta_valid_o), .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i), .out_data_o(out_data_o), .out_last_o(out_last_o)
);

// File: tb/nand_page_fmt_bench.sv
module nand_page_fmt_bench;
  localparam int CLK_PERIOD = 10;
  localparam int M = 3, C = 8, E = 2, P = 2, N = 4, S = 36;
  localparam int PG = M + N * (C + E) + P;
  localparam int USER = N * C;
  localparam int AW = $clog2(PG);
  localparam int IW = 2;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_last = 0, in_ready;
  logic [7:0] in_data = 0;
  logic side_valid, ecc_end, ecc_erased, len_err;
  logic [7:0] side_data;
  logic [1:0] side_kind;
  logic [IW-1:0] side_idx;
  logic fix_we = 0, corr_done = 0;
  logic [AW-1:0] fix_addr = 0;
  logic [7:0] fix_data = 0;
  logic meta_valid, out_valid, out_ready = 0, out_last;
  logic [7:0] meta_data, out_data;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [7:0] exp_raw [PG];

  always #(CLK_PERIOD / 2) clk = ~clk;

  nand_page_fmt #(
    .META_LEN(M), .CHUNK_LEN(C), .ECC_LEN(E), .PAD_LEN(P), .N_CHUNKS(N), .SWAP_OFS(S)
  ) u_nand_page_fmt (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_data_i(in_data),
    .in_last_i(in_last), .in_ready_o(in_ready), .side_valid_o(side_valid),
    .side_data_o(side_data), .side_kind_o(side_kind), .side_idx_o(side_idx),
    .ecc_end_o(ecc_end), .ecc_erased_o(ecc_erased), .len_err_o(len_err),
    .fix_we_i(fix_we), .fix_addr_i(fix_addr), .fix_data_i(fix_data),
    .corr_done_i(corr_done), .meta_valid_o(meta_valid), .meta_data_o(meta_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .out_last_o(out_last)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int kind_of(input int i);
    if (i < M) return 0;
    if (i >= M + N * (C + E)) return 3;
    return (((i - M) % (C + E)) < C) ? 1 : 2;
  endfunction

  function automatic int idx_of(input int i);
    return (i < M) ? 0 : (i - M) / (C + E);
  endfunction

  function automatic logic [7:0] raw_b(input int p, input int i, input logic [3:0] mask);
    int k = kind_of(i);
    if (k == 2 && mask[idx_of(i)]) return 8'hFF;
    if (k == 2 && ((i - M) % (C + E)) == C) return 8'h00;
    return 8'((i * 7 + p * 31 + 5) & 255);
  endfunction

  task automatic send_frame(input int p, input int len, input logic [3:0] mask);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1;
      in_data  = (i < PG) ? raw_b(p, i, mask) : 8'(i);
      in_last  = (i == len - 1);
      if (i < PG) exp_raw[i] = in_data;
      #1;
      chk("R1 in_ready", in_ready, 1);
      begin
        int k = kind_of(i);
        bit sv = (i < PG) && (k != 3);
        bit ee = (i < PG) && (k == 2) && (((i - M) % (C + E)) == C + E - 1);
        chk("R2 side_valid", side_valid, sv);
        if (sv) begin
          chk("R2 side_data", side_data, in_data);
          chk("R2 side_kind", side_kind, k);
          chk("R2 side_idx", side_idx, idx_of(i));
        end
        chk("R3 ecc_end", ecc_end, ee);
        chk("R3 ecc_erased", ecc_erased, ee && mask[idx_of(i)]);
      end
    end
    @(negedge clk);
    in_valid = 0;
    in_last  = 0;
    #1;
    chk("R4 len_err", len_err, len != PG);
    chk("R4 ready after frame", in_ready, len != PG);
  endtask

  task automatic run_page(input int p, input logic [3:0] mask, input bit bp);
    int fa, raddr, guard, u, cyc;
    bit hold;
    logic [7:0] held, t;
    send_frame(p, PG, mask);
    for (int w = 0; w < 2; w++) begin
      @(negedge clk);
      #1;
      chk("R5 ready low", in_ready, 0);
      chk("R5 no meta", meta_valid, 0);
      chk("R5 no out", out_valid, 0);
    end
    fa = M + (p % N) * (C + E) + ((p + 1) % C);
    @(negedge clk);
    fix_we = 1; fix_addr = AW'(fa); fix_data = 8'(p ^ 8'h5A);
    exp_raw[fa] = fix_data;
    @(negedge clk);
    corr_done = 1;
    fix_addr = (p % 2 == 1) ? AW'(0) : AW'(S);
    fix_data = 8'(8'hC0 + p);
    exp_raw[(p % 2 == 1) ? 0 : S] = fix_data;
    @(negedge clk);
    corr_done = 0; fix_we = 0;
    t = exp_raw[0]; exp_raw[0] = exp_raw[S]; exp_raw[S] = t;
    #1;
    chk("R8 meta not yet", meta_valid, 0);
    for (int k = 0; k < M; k++) begin
      @(negedge clk);
      #1;
      chk("R8 meta_valid", meta_valid, 1);
      chk((k == 0) ? "R7 meta marker" : "R8 meta_data", meta_data, exp_raw[k]);
      chk("R8 out idle", out_valid, 0);
    end
    u = 0; hold = 0; held = 0; guard = 0; cyc = 0;
    while (u < USER && guard < 400) begin
      @(negedge clk);
      guard++; cyc++;
      out_ready = bp ? ((cyc % 3) != 0) : 1'b1;
      #1;
      if (out_valid) begin
        if (hold) chk("R10 held data", out_data, held);
        if (out_ready) begin
          raddr = M + (u / C) * (C + E) + (u % C);
          chk((raddr == S) ? "R7 swap pos" : (raddr == fa) ? "R6 fixed byte" : "R9 user",
              out_data, exp_raw[raddr]);
          chk("R9 out_last", out_last, u == USER - 1);
          u++;
          hold = 0;
        end else begin
          hold = 1;
          held = out_data;
        end
      end
    end
    chk("R9 user count", u, USER);
    @(negedge clk);
    out_ready = 0;
    #1;
    chk("R11 ready again", in_ready, 1);
    chk("R11 out idle", out_valid, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset ready", in_ready, 1);
    chk("R8 reset meta", meta_valid, 0);
    chk("R9 reset out", out_valid, 0);
    chk("R4 reset err", len_err, 0);
    rst_n = 1;
    for (int p = 0; p < 16; p++) begin
      run_page(p, 4'(p), p[0]);
      if (p == 4) send_frame(99, PG - 1, 4'h0);
      if (p == 8) send_frame(98, PG + 1, 4'h0);
      if (p == 11) begin
        send_frame(97, 1, 4'h0);
        @(negedge clk);
        corr_done = 1;
        @(negedge clk);
        corr_done = 0;
        for (int w = 0; w < 3; w++) begin
          @(negedge clk);
          #1;
          chk("R4 done ignored meta", meta_valid, 0);
          chk("R4 done ignored ready", in_ready, 1);
        end
      end
    end
    finish_run();
  end
endmodule